// File: doc/BRIEF.md
# MII Management PHY Register Model

This block stands in for the management side of an Ethernet PHY. A host writes a 32-bit management frame. The frame's fields select a read or a write and a register address. A read places 16 bits of result in the low half of the same frame register, where the host can fetch it. A write changes the control, advertisement or interrupt-mask register of the modelled PHY. Every operation, read or write, ends with a one-cycle completion pulse. No serial management pins are toggled: the operation finishes in one clock step after the frame has been captured.

A separate `link_up` input stands for the state of the cable. On every change of that input, the model updates the link and autonegotiation-complete bits of the status register. It also latches the matching event bits in the interrupt-source register. Reading the source register clears it. The source and mask registers are also driven straight out on ports.

The controller is a small state machine with three states. `ST_IDLE` waits for a frame. `ST_READ_EXEC` and `ST_WRITE_EXEC` each run one operation on the captured frame. Every state has the same two transitions. A frame write with bit 29 set moves to `ST_READ_EXEC`. A frame write with bit 29 clear moves to `ST_WRITE_EXEC`. No frame write returns to `ST_IDLE`. This means a new frame can follow directly behind an executing one.

Top module: `phy_mgmt_model`

## Requirements
- R1: A synchronous active-high `rst` sets the frame register to 0, control to 0x3000, status to 0x7809, advertisement to 0x01E1, and mask and sources to 0. It then applies the current `link_up` level as in R10, so after reset with the link down `irq_src` reads 0x10.
- R2: A frame is captured on the edge where `frame_wr` is high. Bit 29 set means a read, bits 27:18 hold the 10-bit register address, and bits 15:0 hold the write data. After the following edge, a read has replaced only bits 15:0 of `frame_rdata`, and a write leaves the captured frame unchanged.
- R3: Reads return fixed values at four addresses: 0x0007 at address 2, 0xC0D1 at address 3, 0x0F71 at address 5 and 0x0001 at address 6. Address 29 returns the sources and address 30 returns the mask, both zero-extended. Every address above 31, and every other address not named here or in R4 and R6, reads 0.
- R4: A write to address 0 with bit 15 clear stores value & 0x7980 in control. If bit 12 of the value is set, it also sets status bit 5 (0x0020) in the same step.
- R5: A write to address 0 with bit 15 set restores every R1 value except the frame register, then reapplies the current link level.
- R6: A write to address 4 stores (value & 0x2D7F) | 0x0080 as the advertisement.
- R7: A write to address 30 stores value & 0xFF as the mask, which `irq_mask` shows.
- R8: A write to any address other than 0, 4 and 30, including all addresses above 31, changes no register.
- R9: A read of address 29 returns the sources as they were before the read, and then clears them to zero.
- R10: A change of `link_up` is detected on the edge where it is first sampled. For a rising link, status bits 0x0024 are set and source bits 7 and 6 are set. For a falling link, status bits 0x0024 are cleared and source bit 4 is set. `irq_src` shows the result after that edge.
- R11: When a link change and the execution of a read of address 29 fall on the same edge, the read returns the old sources, and the sources keep the bits from the new link change.
- R12: `mgmt_done` is high for exactly one cycle, after the second edge following the capture of each frame, whether the frame is a read or a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| frame_wr | input | 1 | Host write strobe for the management frame register |
| frame_wdata | input | FRAME_W | Frame value written by the host |
| link_up | input | 1 | Current cable link level |
| frame_rdata | output | FRAME_W | Current content of the management frame register |
| mgmt_done | output | 1 | One-cycle completion pulse for each operation |
| irq_src | output | 8 | Interrupt-source register (bits 7, 6, 4 used) |
| irq_mask | output | 8 | Interrupt-mask register |

## Verification
A wrong internal register value stays hidden until the host reads that address. The bench therefore follows every write with randomly chosen reads. A stale control, status or advertisement value shows in the low half of `frame_rdata` two edges after the read frame is captured. A wrong source or mask value shows on `irq_src` or `irq_mask` one edge after the operation or link change that caused it. A state machine that picks the wrong state shows up either as a read that leaves the low half untouched or as a write that overwrites it. A missing or doubled `mgmt_done` pulse is visible within the same two-edge window.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int unsigned PHY_DW = 16;
    localparam int unsigned IRQ_W  = 8;

    typedef logic [PHY_DW-1:0] phy_word_t;
    typedef logic [IRQ_W-1:0]  irq_vec_t;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_READ_EXEC  = 2'd1,
        ST_WRITE_EXEC = 2'd2
    } mgmt_state_e;

    // register addresses (the host-visible map)
    localparam int unsigned A_CTRL  = 0;
    localparam int unsigned A_STAT  = 1;
    localparam int unsigned A_ID1   = 2;
    localparam int unsigned A_ID2   = 3;
    localparam int unsigned A_ADV   = 4;
    localparam int unsigned A_LPA   = 5;
    localparam int unsigned A_ANX   = 6;
    localparam int unsigned A_ISRC  = 29;
    localparam int unsigned A_IMASK = 30;

    // reset and constant values
    localparam phy_word_t CTRL_RST   = 16'h3000;
    localparam phy_word_t STAT_RST   = 16'h7809;
    localparam phy_word_t ADV_RST    = 16'h01E1;
    localparam phy_word_t ID1_VAL    = 16'h0007;
    localparam phy_word_t ID2_VAL    = 16'hC0D1;
    localparam phy_word_t LPA_VAL    = 16'h0F71;
    localparam phy_word_t ANX_VAL    = 16'h0001;

    // write shaping
    localparam phy_word_t CTRL_WMASK = 16'h7980;
    localparam phy_word_t ADV_WMASK  = 16'h2D7F;
    localparam phy_word_t ADV_FORCE  = 16'h0080;
    localparam int unsigned SOFT_RST_BIT   = 15;
    localparam int unsigned AN_RESTART_BIT = 12;

    // status bits driven by the link
    localparam phy_word_t STAT_LINK   = 16'h0024;
    localparam phy_word_t STAT_ANDONE = 16'h0020;

    // interrupt source events
    localparam irq_vec_t SRC_UP_EVT   = 8'hC0;
    localparam irq_vec_t SRC_DOWN_EVT = 8'h10;

endpackage

// File: rtl/phy_mgmt_link_watch.sv
module phy_mgmt_link_watch (
    input  logic clk,
    input  logic rst,
    input  logic link_up,
    output logic link_chg
);

    logic link_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            link_q <= link_up;
        end else begin
            link_q <= link_up;
        end
    end

    // a difference between the live level and last sample is a change
    assign link_chg = link_up ^ link_q;

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              clr_src,
    input  logic [ADDR_W-1:0] addr,
    input  phy_word_t         wdata,
    input  logic              link_up,
    input  logic              link_chg,
    output phy_word_t         ctrl_o,
    output phy_word_t         stat_o,
    output phy_word_t         adv_o,
    output irq_vec_t          mask_o,
    output irq_vec_t          src_o
);

    localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_ADV   = ADDR_W'(A_ADV);
    localparam logic [ADDR_W-1:0] AD_IMASK = ADDR_W'(A_IMASK);

    phy_word_t ctrl_q, stat_q, adv_q;
    irq_vec_t  mask_q, src_q;
    phy_word_t ctrl_n, stat_n, adv_n;
    irq_vec_t  mask_n, src_n;
    logic      soft_rst;

    always_comb begin
        ctrl_n   = ctrl_q;
        stat_n   = stat_q;
        adv_n    = adv_q;
        mask_n   = mask_q;
        src_n    = src_q;
        soft_rst = 1'b0;

        if (wr_en) begin
            if (addr == AD_CTRL) begin
                if (wdata[SOFT_RST_BIT]) begin
                    soft_rst = 1'b1;
                end else begin
                    ctrl_n = wdata & CTRL_WMASK;
                    if (wdata[AN_RESTART_BIT]) begin
                        stat_n = stat_n | STAT_ANDONE;
                    end
                end
            end else if (addr == AD_ADV) begin
                adv_n = (wdata & ADV_WMASK) | ADV_FORCE;
            end else if (addr == AD_IMASK) begin
                mask_n = wdata[IRQ_W-1:0];
            end
        end

        if (soft_rst) begin
            ctrl_n = CTRL_RST;
            stat_n = STAT_RST;
            adv_n  = ADV_RST;
            mask_n = '0;
            src_n  = '0;
        end

        // clear-on-read comes before the link merge so new events survive
        if (clr_src) begin
            src_n = '0;
        end

        if (link_chg || soft_rst) begin
            if (link_up) begin
                stat_n = stat_n | STAT_LINK;
                src_n  = src_n | SRC_UP_EVT;
            end else begin
                stat_n = stat_n & ~STAT_LINK;
                src_n  = src_n | SRC_DOWN_EVT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            stat_q <= link_up ? (STAT_RST | STAT_LINK) : STAT_RST;
            adv_q  <= ADV_RST;
            mask_q <= '0;
            src_q  <= link_up ? SRC_UP_EVT : SRC_DOWN_EVT;
        end else begin
            ctrl_q <= ctrl_n;
            stat_q <= stat_n;
            adv_q  <= adv_n;
            mask_q <= mask_n;
            src_q  <= src_n;
        end
    end

    assign ctrl_o = ctrl_q;
    assign stat_o = stat_q;
    assign adv_o  = adv_q;
    assign mask_o = mask_q;
    assign src_o  = src_q;

endmodule

// File: rtl/phy_mgmt_rdmux.sv
module phy_mgmt_rdmux
    import phy_mgmt_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  phy_word_t         ctrl,
    input  phy_word_t         stat,
    input  phy_word_t         adv,
    input  irq_vec_t          mask,
    input  irq_vec_t          src,
    output phy_word_t         rd_val
);

    localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_STAT  = ADDR_W'(A_STAT);
    localparam logic [ADDR_W-1:0] AD_ID1   = ADDR_W'(A_ID1);
    localparam logic [ADDR_W-1:0] AD_ID2   = ADDR_W'(A_ID2);
    localparam logic [ADDR_W-1:0] AD_ADV   = ADDR_W'(A_ADV);
    localparam logic [ADDR_W-1:0] AD_LPA   = ADDR_W'(A_LPA);
    localparam logic [ADDR_W-1:0] AD_ANX   = ADDR_W'(A_ANX);
    localparam logic [ADDR_W-1:0] AD_ISRC  = ADDR_W'(A_ISRC);
    localparam logic [ADDR_W-1:0] AD_IMASK = ADDR_W'(A_IMASK);

    always_comb begin
        case (addr)
            AD_CTRL:  rd_val = ctrl;
            AD_STAT:  rd_val = stat;
            AD_ID1:   rd_val = ID1_VAL;
            AD_ID2:   rd_val = ID2_VAL;
            AD_ADV:   rd_val = adv;
            AD_LPA:   rd_val = LPA_VAL;
            AD_ANX:   rd_val = ANX_VAL;
            AD_ISRC:  rd_val = PHY_DW'(src);
            AD_IMASK: rd_val = PHY_DW'(mask);
            default:  rd_val = '0;
        endcase
    end

endmodule

// File: rtl/phy_mgmt_model.sv
module phy_mgmt_model
    import phy_mgmt_pkg::*;
#(
    parameter int unsigned FRAME_W  = 32,
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned RD_BIT   = 29,
    parameter int unsigned ADDR_LSB = 18
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_wr,
    input  logic [FRAME_W-1:0] frame_wdata,
    input  logic               link_up,
    output logic [FRAME_W-1:0] frame_rdata,
    output logic               mgmt_done,
    output logic [IRQ_W-1:0]   irq_src,
    output logic [IRQ_W-1:0]   irq_mask
);

    localparam logic [ADDR_W-1:0] AD_ISRC = ADDR_W'(A_ISRC);

    mgmt_state_e       state, state_nxt;
    logic [FRAME_W-1:0] frame_q;
    logic              done_q;
    logic              rd_exec, wr_exec;
    logic              link_chg;
    logic [ADDR_W-1:0] op_addr;
    phy_word_t         op_data;
    phy_word_t         rd_val;
    phy_word_t         ctrl_v, stat_v, adv_v;
    irq_vec_t          mask_v, src_v;

    // fields of the captured frame
    assign op_addr = frame_q[ADDR_LSB +: ADDR_W];
    assign op_data = frame_q[PHY_DW-1:0];

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next state: every state follows the incoming frame
    always_comb begin
        state_nxt = ST_IDLE;
        if (frame_wr) begin
            state_nxt = frame_wdata[RD_BIT] ? ST_READ_EXEC : ST_WRITE_EXEC;
        end
    end

    // state outputs
    always_comb begin
        rd_exec = 1'b0;
        wr_exec = 1'b0;
        unique case (state)
            ST_IDLE:       begin rd_exec = 1'b0; wr_exec = 1'b0; end
            ST_READ_EXEC:  rd_exec = 1'b1;
            ST_WRITE_EXEC: wr_exec = 1'b1;
            default:       begin rd_exec = 1'b0; wr_exec = 1'b0; end
        endcase
    end

    // frame register: a new host write wins over a read result
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
        end else if (frame_wr) begin
            frame_q <= frame_wdata;
        end else if (rd_exec) begin
            frame_q <= {frame_q[FRAME_W-1:PHY_DW], rd_val};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else begin
            done_q <= rd_exec | wr_exec;
        end
    end

    phy_mgmt_link_watch u_link (
        .clk      (clk),
        .rst      (rst),
        .link_up  (link_up),
        .link_chg (link_chg)
    );

    phy_mgmt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_exec),
        .clr_src  (rd_exec && (op_addr == AD_ISRC)),
        .addr     (op_addr),
        .wdata    (op_data),
        .link_up  (link_up),
        .link_chg (link_chg),
        .ctrl_o   (ctrl_v),
        .stat_o   (stat_v),
        .adv_o    (adv_v),
        .mask_o   (mask_v),
        .src_o    (src_v)
    );

    phy_mgmt_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
        .addr   (op_addr),
        .ctrl   (ctrl_v),
        .stat   (stat_v),
        .adv    (adv_v),
        .mask   (mask_v),
        .src    (src_v),
        .rd_val (rd_val)
    );

    assign frame_rdata = frame_q;
    assign mgmt_done   = done_q;
    assign irq_src     = src_v;
    assign irq_mask    = mask_v;

endmodule

// File: rtl/phy_mgmt_model_chk.sv
module phy_mgmt_model_chk
    import phy_mgmt_pkg::*;
#(
    parameter int unsigned FRAME_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               frame_wr,
    input logic               link_up,
    input logic               rd_exec,
    input logic [FRAME_W-1:0] frame_rdata,
    input logic               mgmt_done,
    input logic [IRQ_W-1:0]   irq_src
);

    // R12
    done_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        mgmt_done |-> $past(frame_wr, 2));

    // R12
    op_gives_done_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(frame_wr, 2) && !$past(rst, 1) && !$past(rst, 2)) |-> mgmt_done);

    // R2
    read_keeps_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_exec && !frame_wr) |=> $stable(frame_rdata[FRAME_W-1:PHY_DW]));

    // R10
    link_rise_evt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_up) |=> (irq_src[7] && irq_src[6]));

    // R10
    link_fall_evt_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(link_up) |=> irq_src[4]);

    // R10
    src_legal_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_src & ~(SRC_UP_EVT | SRC_DOWN_EVT)) == '0);

endmodule

bind phy_mgmt_model phy_mgmt_model_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_wr    (frame_wr),
    .link_up     (link_up),
    .rd_exec     (rd_exec),
    .frame_rdata (frame_rdata),
    .mgmt_done   (mgmt_done),
    .irq_src     (irq_src)
);

// File: tb/test_phy_mgmt_model.sv
`timescale 1ns/1ps
module test_phy_mgmt_model;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_wr;
    logic [31:0] frame_wdata;
    logic        link_up;
    logic [31:0] frame_rdata;
    logic        mgmt_done;
    logic [7:0]  irq_src;
    logic [7:0]  irq_mask;

    int n_cmp  = 0;
    int n_miss = 0;
    bit finished = 1'b0;

    // bench model of the PHY registers
    logic [15:0] m_ctrl, m_stat, m_adv;
    logic [7:0]  m_mask, m_src;
    logic        m_link;

    always #10 clk = ~clk;

    phy_mgmt_model i_phy_mgmt_model (
        .clk         (clk),
        .rst         (rst),
        .frame_wr    (frame_wr),
        .frame_wdata (frame_wdata),
        .link_up     (link_up),
        .frame_rdata (frame_rdata),
        .mgmt_done   (mgmt_done),
        .irq_src     (irq_src),
        .irq_mask    (irq_mask)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [9:0] a);
        case (a)
            10'd0:   return m_ctrl;
            10'd1:   return m_stat;
            10'd2:   return 16'h0007;
            10'd3:   return 16'hC0D1;
            10'd4:   return m_adv;
            10'd5:   return 16'h0F71;
            10'd6:   return 16'h0001;
            10'd29:  return {8'h00, m_src};
            10'd30:  return {8'h00, m_mask};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_link();
        if (m_link) begin
            m_stat = m_stat | 16'h0024;
            m_src  = m_src | 8'hC0;
        end else begin
            m_stat = m_stat & ~16'h0024;
            m_src  = m_src | 8'h10;
        end
    endtask

    task automatic model_reset();
        m_ctrl = 16'h3000;
        m_stat = 16'h7809;
        m_adv  = 16'h01E1;
        m_mask = 8'h00;
        m_src  = 8'h00;
        model_link();
    endtask

    task automatic model_write(input logic [9:0] a, input logic [15:0] d);
        if (a == 10'd0) begin
            if (d[15]) begin
                model_reset();
            end else begin
                m_ctrl = d & 16'h7980;
                if (d[12]) m_stat = m_stat | 16'h0020;
            end
        end else if (a == 10'd4) begin
            m_adv = (d & 16'h2D7F) | 16'h0080;
        end else if (a == 10'd30) begin
            m_mask = d[7:0];
        end
    endtask

    function automatic logic [31:0] make_frame(input bit rd, input logic [9:0] a,
                                               input logic [15:0] d, input logic [31:0] fill);
        logic [31:0] f;
        f = fill;
        f[29] = rd;
        f[27:18] = a;
        f[15:0] = d;
        return f;
    endfunction

    // one operation: drive, wait two edges, compare
    task automatic run_op(input bit rd, input logic [9:0] a, input logic [15:0] d, input string tag);
        logic [31:0] f;
        logic [31:0] exp_f;
        f = make_frame(rd, a, d, $urandom());
        @(negedge clk);
        frame_wr = 1'b1;
        frame_wdata = f;
        @(negedge clk);
        frame_wr = 1'b0;
        chk(mgmt_done == 1'b0, "R12 done early", {31'd0, mgmt_done}, 32'd0);
        @(negedge clk);
        if (rd) begin
            exp_f = {f[31:16], exp_read(a)};
            if (a == 10'd29) m_src = 8'h00;
        end else begin
            exp_f = f;
            model_write(a, d);
        end
        chk(frame_rdata == exp_f, tag, frame_rdata, exp_f);
        chk(mgmt_done == 1'b1, "R12 done pulse", {31'd0, mgmt_done}, 32'd1);
        chk(irq_src == m_src, (rd && a == 10'd29) ? "R9 sources cleared" : "R10 sources",
            {24'd0, irq_src}, {24'd0, m_src});
        chk(irq_mask == m_mask, "R7 mask port", {24'd0, irq_mask}, {24'd0, m_mask});
        @(negedge clk);
        chk(mgmt_done == 1'b0, "R12 done one cycle", {31'd0, mgmt_done}, 32'd0);
    endtask

    task automatic set_link(input logic v);
        @(negedge clk);
        link_up = v;
        @(negedge clk);
        if (v != m_link) begin
            m_link = v;
            model_link();
        end
        chk(irq_src == m_src, "R10 link event", {24'd0, irq_src}, {24'd0, m_src});
    endtask

    // read of the source register executing on the same edge as a link change
    task automatic read29_with_link(input logic v);
        logic [31:0] f;
        logic [31:0] exp_f;
        f = make_frame(1'b1, 10'd29, 16'h0000, 32'h0);
        @(negedge clk);
        frame_wr = 1'b1;
        frame_wdata = f;
        @(negedge clk);
        frame_wr = 1'b0;
        link_up = v;
        @(negedge clk);
        exp_f = {f[31:16], 8'h00, m_src};
        m_src = 8'h00;
        m_link = v;
        model_link();
        chk(frame_rdata == exp_f, "R11 old sources returned", frame_rdata, exp_f);
        chk(irq_src == m_src, "R11 new link bits kept", {24'd0, irq_src}, {24'd0, m_src});
    endtask

    function automatic logic [9:0] pick_addr(input logic [31:0] r);
        case (r[11:8])
            4'd0:  return 10'd0;
            4'd1:  return 10'd1;
            4'd2:  return 10'd2;
            4'd3:  return 10'd3;
            4'd4:  return 10'd4;
            4'd5:  return 10'd5;
            4'd6:  return 10'd6;
            4'd7:  return 10'd17;
            4'd8:  return 10'd18;
            4'd9:  return 10'd27;
            4'd10: return 10'd29;
            4'd11: return 10'd30;
            4'd12: return 10'd31;
            4'd13: return 10'd7;
            default: return r[31:22];
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_miss++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        frame_wr = 1'b0;
        frame_wdata = '0;
        link_up = 1'b0;
        m_link = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();

        // R1 reset state
        chk(frame_rdata == 32'h0, "R1 frame reset", frame_rdata, 32'h0);
        chk(mgmt_done == 1'b0, "R1 done reset", {31'd0, mgmt_done}, 32'd0);
        chk(irq_src == 8'h10, "R1 sources with link down", {24'd0, irq_src}, 32'h10);
        chk(irq_mask == 8'h00, "R1 mask reset", {24'd0, irq_mask}, 32'h0);
        run_op(1'b1, 10'd1, 16'h0, "R1 status reset");
        run_op(1'b1, 10'd0, 16'h0, "R1 control reset");
        run_op(1'b1, 10'd4, 16'h0, "R1 advertisement reset");

        // R10, R9 link up and clear-on-read
        set_link(1'b1);
        run_op(1'b1, 10'd1, 16'h0, "R10 status link up");
        run_op(1'b1, 10'd29, 16'h0, "R9 read sources");
        run_op(1'b1, 10'd29, 16'h0, "R9 sources now zero");
        set_link(1'b0);
        run_op(1'b1, 10'd1, 16'h0, "R10 status link down");

        // R4 control write and autonegotiation restart
        run_op(1'b0, 10'd0, 16'h1200, "R4 control write");
        run_op(1'b1, 10'd0, 16'h0, "R4 control masked");
        run_op(1'b1, 10'd1, 16'h0, "R4 status bit 5");

        // R6 advertisement shaping
        run_op(1'b0, 10'd4, 16'hFFFF, "R6 adv write ones");
        run_op(1'b1, 10'd4, 16'h0, "R6 adv ones");
        run_op(1'b0, 10'd4, 16'h0000, "R6 adv write zeros");
        run_op(1'b1, 10'd4, 16'h0, "R6 adv forced bit");

        // R7 mask
        run_op(1'b0, 10'd30, 16'h1234, "R7 mask write");
        run_op(1'b1, 10'd30, 16'h0, "R7 mask read");

        // R3, R8 fixed, unlisted and out-of-range addresses
        run_op(1'b0, 10'd2, 16'hABCD, "R8 write to id");
        run_op(1'b1, 10'd2, 16'h0, "R8 id unchanged");
        run_op(1'b0, 10'd40, 16'h0000, "R8 write above 31");
        run_op(1'b1, 10'd0, 16'h0, "R8 control unchanged");
        run_op(1'b1, 10'd40, 16'h0, "R3 above 31 reads zero");
        run_op(1'b1, 10'h3FF, 16'h0, "R3 top address zero");
        run_op(1'b1, 10'd3, 16'h0, "R3 id low");
        run_op(1'b1, 10'd5, 16'h0, "R3 partner ability");
        run_op(1'b1, 10'd6, 16'h0, "R3 expansion");
        run_op(1'b1, 10'd17, 16'h0, "R3 unlisted zero");

        // R5 soft reset
        run_op(1'b0, 10'd0, 16'h8000, "R5 soft reset write");
        run_op(1'b1, 10'd4, 16'h0, "R5 adv restored");
        run_op(1'b1, 10'd1, 16'h0, "R5 status restored");

        // R11 collision of clear-on-read with link change
        read29_with_link(1'b1);
        read29_with_link(1'b0);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            logic [31:0] d;
            logic [9:0]  a;
            r = $urandom();
            d = $urandom();
            if (r[3:0] == 4'd0) begin
                set_link(~m_link);
            end else begin
                a = pick_addr(r);
                if (a == 10'd0 && r[6:5] != 2'd0) d[15] = 1'b0;
                run_op(r[4], a, d[15:0], "R2 random op");
            end
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
        $finish;
    end

endmodule